// File: doc/BRIEF.md
# Channel Test Pattern Injector

This block sits in one ADC channel's data path, just ahead of the output serializer. On every sample strobe it registers one 24-bit word for the serializer. That word is either the live conversion result or a synthetic test word. With the pattern enable low, conversion data passes through unchanged.

With the enable high, a 2-bit selector picks the pattern source:
- a constant word (selector codes 0 and 1 both do this);
- an incrementing ramp whose step is the programmed 4-bit value plus one;
- a pair of words that alternate.

Each channel has its own instance with its own controls. Each instance keeps its own ramp and alternation state, so one channel's settings never touch the other. Register decoding and serialization live elsewhere.

Top module: `tpg_channel`

## Requirements
- R1: After reset, `data_o` is 0 and no strobe has yet been seen in ramp or alternate mode.
- R2: On a strobe with `tp_on_i` = 0, `data_o` takes the value of `conv_i` in the following cycle.
- R3: `data_o` changes only on the cycle after a strobe. Changes to any input between strobes have no effect on `data_o`. Controls are sampled only in the strobe cycle.
- R4: On a strobe with `tp_on_i` = 1 and `tp_sel_i` = 2'b00 or 2'b01, `data_o` becomes `word0_i`.
- R5: On a strobe with `tp_on_i` = 1 and `tp_sel_i` = 2'b10, the ramp is active. If the previous strobe was also an enabled ramp strobe, `data_o` becomes the previous `data_o` plus `step_i` + 1, so the increment ranges from 1 to 16.
- R6: The ramp wraps modulo 2^W, where W = 24 by default.
- R7: A ramp strobe whose previous strobe was not an enabled ramp strobe restarts the ramp. This covers reset, the enable rising and a change of mode. The output on a restart is 0.
- R8: On a strobe with `tp_on_i` = 1 and `tp_sel_i` = 2'b11, the first such strobe after entry outputs `word0_i`. Each following consecutive enabled alternate strobe switches to the other word (`word1_i`, then `word0_i`, and so on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Sample strobe, one cycle per sample |
| conv_i | input | W | Conversion result for this channel |
| tp_on_i | input | 1 | 1 selects a test pattern, 0 passes conversion data |
| tp_sel_i | input | 2 | Pattern selector: 00/01 constant, 10 ramp, 11 alternate |
| step_i | input | 4 | Ramp step minus one |
| word0_i | input | W | First pattern word |
| word1_i | input | W | Second pattern word |
| data_o | output | W | Registered output word |

## Verification
The strobe that updates the output can also be the strobe that restarts a sequence. This happens when the enable rises, or the selector changes, in the same cycle as a ramp or alternate strobe.

The random stimulus keeps the configuration for runs of strobes and then changes the enable, the selector and the step on a strobe. Every restart therefore coincides with a data update. The bench model judges each such strobe: a ramp must emit 0 and an alternation must emit `word0_i`, and neither may continue from older state.

Idle cycles between strobes churn every input. The output must stay frozen through them.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        SEL_FIX0 = 2'b00,
        SEL_FIX1 = 2'b01,
        SEL_RAMP = 2'b10,
        SEL_ALT  = 2'b11
    } tpg_sel_e;
endpackage

// File: rtl/tpg_ramp_next.sv
module tpg_ramp_next #(
    parameter int W      = 24,
    parameter int STEP_W = 4
) (
    input  logic [W-1:0]      cur_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              restart_i,
    output logic [W-1:0]      nxt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (restart_i) nxt_o = '0;
        else           nxt_o = cur_i + W'(step_i) + ONE;
    end
endmodule

// File: rtl/tpg_alt_next.sv
module tpg_alt_next (
    input  logic restart_i,
    input  logic last_hi_i,
    output logic pick_hi_o
);
    always_comb pick_hi_o = restart_i ? 1'b0 : ~last_hi_i;
endmodule

// File: rtl/tpg_src_mux.sv
module tpg_src_mux
    import tpg_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         on_i,
    input  tpg_sel_e     sel_i,
    input  logic [W-1:0] conv_i,
    input  logic [W-1:0] w0_i,
    input  logic [W-1:0] w1_i,
    input  logic [W-1:0] ramp_i,
    input  logic         pick_hi_i,
    output logic [W-1:0] out_o
);
    always_comb begin
        if (!on_i) begin
            out_o = conv_i;
        end else begin
            unique case (sel_i)
                SEL_FIX0, SEL_FIX1: out_o = w0_i;
                SEL_RAMP:           out_o = ramp_i;
                SEL_ALT:            out_o = pick_hi_i ? w1_i : w0_i;
                default:            out_o = w0_i;
            endcase
        end
    end
endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
    import tpg_pkg::*;
#(
    parameter int W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [W-1:0]      conv_i,
    input  logic              tp_on_i,
    input  logic [1:0]        tp_sel_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [W-1:0]      word0_i,
    input  logic [W-1:0]      word1_i,
    output logic [W-1:0]      data_o
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic         ramp_live;
        logic         alt_live;
        logic         alt_hi;
    } state_t;

    state_t s_d, s_q;

    tpg_sel_e     sel;
    logic         is_ramp, is_alt;
    logic [W-1:0] ramp_val;
    logic         pick_hi;
    logic [W-1:0] mux_out;

    assign sel     = tpg_sel_e'(tp_sel_i);
    assign is_ramp = tp_on_i && (sel == SEL_RAMP);
    assign is_alt  = tp_on_i && (sel == SEL_ALT);

    tpg_ramp_next #(.W(W), .STEP_W(STEP_W)) u_ramp (
        .cur_i     (s_q.dout),
        .step_i    (step_i),
        .restart_i (!s_q.ramp_live),
        .nxt_o     (ramp_val)
    );

    tpg_alt_next u_alt (
        .restart_i (!s_q.alt_live),
        .last_hi_i (s_q.alt_hi),
        .pick_hi_o (pick_hi)
    );

    tpg_src_mux #(.W(W)) u_mux (
        .on_i      (tp_on_i),
        .sel_i     (sel),
        .conv_i    (conv_i),
        .w0_i      (word0_i),
        .w1_i      (word1_i),
        .ramp_i    (ramp_val),
        .pick_hi_i (pick_hi),
        .out_o     (mux_out)
    );

    always_comb begin
        s_d = s_q;
        if (strobe_i) begin
            s_d.dout      = mux_out;
            s_d.ramp_live = is_ramp;
            s_d.alt_live  = is_alt;
            if (is_alt) s_d.alt_hi = pick_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_o = s_q.dout;
endmodule

// File: rtl/tpg_channel_chk.sv
module tpg_channel_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         strobe_i,
    input logic [W-1:0] conv_i,
    input logic         tp_on_i,
    input logic [1:0]   tp_sel_i,
    input logic [3:0]   step_i,
    input logic [W-1:0] word0_i,
    input logic [W-1:0] word1_i,
    input logic [W-1:0] data_o
);
    logic in_ramp, in_alt, alt_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ramp <= 1'b0;
            in_alt  <= 1'b0;
            alt_hi  <= 1'b0;
        end else if (strobe_i) begin
            in_ramp <= tp_on_i && tp_sel_i == 2'b10;
            in_alt  <= tp_on_i && tp_sel_i == 2'b11;
            if (tp_on_i && tp_sel_i == 2'b11) alt_hi <= in_alt ? ~alt_hi : 1'b0;
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(data_o));

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !tp_on_i) |=> data_o == $past(conv_i));

    assert_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tp_on_i && !tp_sel_i[1]) |=> data_o == $past(word0_i));

    assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tp_on_i && tp_sel_i == 2'b10 && in_ramp)
        |=> data_o == $past(data_o) + W'($past(step_i)) + W'(1));

    assert_ramp_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tp_on_i && tp_sel_i == 2'b10 && !in_ramp) |=> data_o == '0);

    assert_alt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tp_on_i && tp_sel_i == 2'b11 && !in_alt) |=> data_o == $past(word0_i));

    assert_alt_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && tp_on_i && tp_sel_i == 2'b11 && in_alt)
        |=> data_o == (alt_hi ? $past(word1_i) : $past(word0_i)));
endmodule

bind tpg_channel tpg_channel_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .conv_i   (conv_i),
    .tp_on_i  (tp_on_i),
    .tp_sel_i (tp_sel_i),
    .step_i   (step_i),
    .word0_i  (word0_i),
    .word1_i  (word1_i),
    .data_o   (data_o)
);

// File: tb/tpg_channel_test.sv
`timescale 1ns/1ps
module tpg_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [23:0] conv = '0;
    logic        on = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [3:0]  step = 4'd0;
    logic [23:0] w0 = '0;
    logic [23:0] w1 = '0;
    logic [23:0] dout;
    logic [7:0]  n_dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [23:0] m_out = '0;
    bit m_rl = 0, m_al = 0, m_hi = 0;

    always #2 clk = ~clk;

    tpg_channel uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .conv_i(conv),
        .tp_on_i(on), .tp_sel_i(sel), .step_i(step),
        .word0_i(w0), .word1_i(w1), .data_o(dout)
    );

    tpg_channel #(.W(8)) uut_w8 (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .conv_i(conv[7:0]),
        .tp_on_i(on), .tp_sel_i(sel), .step_i(step),
        .word0_i(w0[7:0]), .word1_i(w1[7:0]), .data_o(n_dout)
    );

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Model from the requirements; returns tag of the rule applied.
    function automatic string model_step(output logic [23:0] e);
        string r;
        bit hi;
        if (!on) begin
            e = conv; r = "R2";
        end else begin
            case (sel)
                2'b00, 2'b01: begin e = w0; r = "R4"; end
                2'b10: begin
                    if (m_rl) begin e = m_out + 24'(step) + 24'd1; r = "R5"; end
                    else      begin e = '0; r = "R7"; end
                end
                default: begin
                    hi = m_al ? ~m_hi : 1'b0;
                    e = hi ? w1 : w0;
                    m_hi = hi;
                    r = "R8";
                end
            endcase
        end
        m_rl = on && sel == 2'b10;
        m_al = on && sel == 2'b11;
        m_out = e;
        return r;
    endfunction

    task automatic strobe_once();
        logic [23:0] e;
        string r;
        @(negedge clk);
        strobe = 1'b1;
        r = model_step(e);
        @(negedge clk);
        strobe = 1'b0;
        check(dout, e, r);
    endtask

    task automatic idle_churn(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            conv = 24'($urandom); w0 = 24'($urandom); w1 = 24'($urandom);
            sel = 2'($urandom); step = 4'($urandom); on = 1'($urandom);
            @(negedge clk);
            check(dout, m_out, "R3");
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(dout, 24'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(dout, 24'd0, "R1");

        // R2 passthrough
        on = 0; conv = 24'hABCDEF; strobe_once();
        // R4 both constant codes
        on = 1; sel = 2'b00; w0 = 24'h123456; strobe_once();
        sel = 2'b01; w0 = 24'h654321; strobe_once();
        // R7 entry, R5 steps of 1 and 16
        sel = 2'b10; step = 4'd0; strobe_once(); strobe_once(); strobe_once();
        step = 4'd15; strobe_once(); strobe_once();
        // R3 hold while inputs churn, then re-entry restarts (R7)
        idle_churn(4);
        on = 1; sel = 2'b00; strobe_once();
        sel = 2'b10; step = 4'd3; strobe_once(); strobe_once();
        on = 0; strobe_once(); on = 1; strobe_once(); strobe_once();
        // R8 alternation starting with word0
        sel = 2'b11; w0 = 24'h0A0A0A; w1 = 24'hB0B0B0;
        repeat (5) strobe_once();
        sel = 2'b01; strobe_once(); sel = 2'b11; strobe_once(); strobe_once();

        // R6 wrap on the 8-bit instance: ramp from entry, step 5
        sel = 2'b00; strobe_once();
        sel = 2'b10; step = 4'd4;
        for (int k = 0; k < 60; k++) begin
            strobe_once();
            check({16'd0, n_dout}, {16'd0, 8'((k * 5) % 256)}, "R6");
        end

        // Random runs with configuration held for a while
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                on = ($urandom_range(0, 4) != 0);
                sel = 2'($urandom);
                step = 4'($urandom);
            end
            conv = 24'($urandom); w0 = 24'($urandom); w1 = 24'($urandom);
            strobe_once();
            if ($urandom_range(0, 9) == 0) idle_churn(2);
        end

        finish_run();
    end
endmodule